// File: doc/BRIEF.md
# PPS-Disciplined Time-of-Day Keeper

This block keeps a local time of day (hours, minutes, seconds plus a sub-second tick count) and steers it from two GPS inputs. The first is a pulse-per-second line. The second is a decoded time-of-day value delivered as a one-cycle load pulse. A tick counter measures time inside the current second. An accepted PPS rising edge restarts the counter, and a decoded time value takes effect at the next accepted edge.

The block starts unlocked and takes the first edge it sees. It then locks and accepts edges only inside a window of ±`WIN_TICKS` clock ticks around the expected boundary. If a window passes with no edge, the block enters holdover and keeps counting seconds from the local clock.

The block records the tick counts between consecutive accepted edges and keeps the last five. The median of those five replaces the ticks-per-second value in two cases: when a calibration request arrives, and when the lock is lost.

Top module: `pps_time_keeper`

## Requirements
- R1: During reset the outputs read as follows: tick 0, time 00:00:00, lock state 0 (unlocked), and second length equal to `NOM_TICKS`.
- R2: The lock state is encoded as 0 = unlocked, 1 = locked and 2 = holdover. When unlocked, any rising edge on `pps_in` is accepted and the state becomes locked.
- R3: An accepted edge sampled at a clock edge makes the tick output read 0 after that clock edge.
- R4: In the locked and holdover states, an edge is accepted only while tick ≥ length−`WIN_TICKS` or tick < `WIN_TICKS`. Any other edge is ignored: the tick keeps counting and the time does not change.
- R5: An edge accepted with tick ≥ length−`WIN_TICKS` advances the time by one second. An edge accepted with tick < `WIN_TICKS` (after the local rollover) only realigns the tick and does not advance the second again.
- R6: A load pulse captures hours, minutes and seconds. The captured value appears on the time outputs unchanged at the next accepted edge and not earlier. It takes priority over the one-second advance.
- R7: The locked state changes to holdover when the tick reaches `WIN_TICKS` with no accepted edge since the window opened. Holdover returns to locked on an accepted edge. The unlocked state never goes directly to holdover.
- R8: With no accepted edge, the tick wraps from length−1 to 0 and the time advances by one second. Seconds and minutes wrap at 60, and hours wrap at 24.
- R9: Each interval is the number of clock cycles between two consecutive accepted edges. An interval is recorded only if no window was missed between the two edges, and only the last five recorded intervals are kept.
- R10: Once five intervals are held, a calibration request or a change from locked to holdover loads the second length with their median. Otherwise the second length is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_in | input | 1 | Pulse-per-second level, rising edge significant |
| tod_load | input | 1 | One-cycle strobe carrying a decoded time of day |
| tod_hr_in | input | 5 | Decoded hours, 0..23 |
| tod_min_in | input | 6 | Decoded minutes, 0..59 |
| tod_sec_in | input | 6 | Decoded seconds, 0..59 |
| cal_req | input | 1 | Calibration request |
| sub_tick | output | TW | Ticks since the current second began |
| hr_out | output | 5 | Hours |
| min_out | output | 6 | Minutes |
| sec_out | output | 6 | Seconds |
| lock_state | output | 2 | 0 unlocked, 1 locked, 2 holdover |
| sec_len | output | TW | Ticks per second in use |

## Verification
The range checks on the time outputs assume that every decoded time loaded through `tod_load` is a legal time of day. The stimulus loads only legal values, including the 23:59:59 corner. The window logic assumes that the second length stays well above twice `WIN_TICKS`. The bench keeps all measured intervals near the nominal length so that every median it produces meets this. PPS is driven as short single pulses synchronous to the clock, so that each pulse gives exactly one rising edge.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

  typedef enum logic [1:0] {
    ST_UNSYNC = 2'd0,
    ST_SYNC   = 2'd1,
    ST_HOLD   = 2'd2
  } lock_e;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } tod_t;

  // One-second step with 60/60/24 carry.
  function automatic tod_t tod_step(tod_t t);
    tod_t n;
    n = t;
    if (t.sc == 6'd59) begin
      n.sc = 6'd0;
      if (t.mn == 6'd59) begin
        n.mn = 6'd0;
        n.hr = (t.hr == 5'd23) ? 5'd0 : t.hr + 5'd1;
      end else begin
        n.mn = t.mn + 6'd1;
      end
    end else begin
      n.sc = t.sc + 6'd1;
    end
    return n;
  endfunction

endpackage

// File: rtl/ppt_median.sv
module ppt_median #(
  parameter int W = 16,
  parameter int N = 5
) (
  input  logic [N-1:0][W-1:0] samples,
  output logic [W-1:0]        median
);
  localparam int MID = N / 2;

  logic [N-1:0] pick;

  // Stable rank: equal values are ordered by index, so exactly one rank equals MID.
  for (genvar i = 0; i < N; i++) begin : g_rank
    logic hit;
    always_comb begin
      int below;
      below = 0;
      for (int j = 0; j < N; j++) begin
        if ((samples[j] < samples[i]) || ((samples[j] == samples[i]) && (j < i)))
          below = below + 1;
      end
      hit = (below == MID);
    end
    assign pick[i] = hit;
  end

  always_comb begin
    median = '0;
    for (int i = 0; i < N; i++) begin
      if (pick[i]) median = median | samples[i];
    end
  end

endmodule

// File: rtl/ppt_tick_fsm.sv
module ppt_tick_fsm
  import ppt_pkg::*;
#(
  parameter int TW  = 28,
  parameter int WIN = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pps_in,
  input  logic [TW-1:0] tps,
  output logic [TW-1:0] tick,
  output lock_e         state,
  output logic          accept,
  output logic          late,
  output logic          rollover,
  output logic          miss
);
  localparam logic [TW-1:0] WIN_V = TW'(WIN);
  localparam logic [TW-1:0] ONE   = TW'(1);

  logic          pps_q, got_q;
  logic [TW-1:0] tick_q;
  lock_e         state_q;
  logic          pps_edge, win_open;

  assign pps_edge = pps_in & ~pps_q;
  assign win_open = (tick_q >= tps - WIN_V) || (tick_q < WIN_V);
  assign accept   = pps_edge && ((state_q == ST_UNSYNC) || (win_open && !got_q));
  assign late     = accept && (state_q != ST_UNSYNC) && (tick_q < WIN_V);
  assign rollover = !accept && (tick_q >= tps - ONE);
  assign miss     = (state_q != ST_UNSYNC) && (tick_q == WIN_V) && !got_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pps_q   <= 1'b0;
      got_q   <= 1'b0;
      tick_q  <= '0;
      state_q <= ST_UNSYNC;
    end else begin
      pps_q <= pps_in;
      if (accept || rollover) tick_q <= '0;
      else                    tick_q <= tick_q + ONE;
      if (accept)                             got_q <= 1'b1;
      else if (tick_q == tps - WIN_V - ONE)   got_q <= 1'b0;
      case (state_q)
        ST_UNSYNC: if (accept) state_q <= ST_SYNC;
        ST_SYNC:   if (miss)   state_q <= ST_HOLD;
        ST_HOLD:   if (accept) state_q <= ST_SYNC;
        default:               state_q <= ST_UNSYNC;
      endcase
    end
  end

  assign tick  = tick_q;
  assign state = state_q;

  a_r3_accept_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tick_q == '0));

  a_r4_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_edge && (state_q != ST_UNSYNC) && !win_open) |=> (tick_q == $past(tick_q) + ONE));

  a_r7_unsync_not_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNSYNC) |=> (state_q != ST_HOLD));

  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && (tick_q >= tps - ONE)) |=> (tick_q == '0));

endmodule

// File: rtl/ppt_tod.sv
module ppt_tod
  import ppt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tod_load,
  input  tod_t tod_in,
  input  logic accept,
  input  logic advance,
  output tod_t cur
);
  tod_t cur_q, pend_q;
  logic pend_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else begin
      if (accept && pend_v) cur_q <= pend_q;
      else if (advance)     cur_q <= tod_step(cur_q);
      if (tod_load) begin
        pend_q <= tod_in;
        pend_v <= 1'b1;
      end else if (accept) begin
        pend_v <= 1'b0;
      end
    end
  end

  assign cur = cur_q;

  a_r6_applied_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pend_v) |=> (cur_q == $past(pend_q)));

  a_r6_no_early_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !advance) |=> $stable(cur_q));

  a_r8_fields_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.sc < 6'd60) && (cur_q.mn < 6'd60) && (cur_q.hr < 5'd24));

endmodule

// File: rtl/ppt_calib.sv
module ppt_calib #(
  parameter int TW    = 28,
  parameter int NOM   = 50_000_000,
  parameter int DEPTH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          miss,
  input  logic          apply,
  output logic [TW-1:0] tps
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0]             meas_q, tps_q, med;
  logic                      prev_q, full;
  logic [DEPTH-1:0][TW-1:0]  hist_q;
  logic [CW-1:0]             fill_q;

  ppt_median #(.W(TW), .N(DEPTH)) u_med (
    .samples (hist_q),
    .median  (med)
  );

  assign full = (fill_q == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_q <= '0;
      prev_q <= 1'b0;
      hist_q <= '0;
      fill_q <= '0;
      tps_q  <= TW'(NOM);
    end else begin
      if (accept)              meas_q <= ONE;
      else if (meas_q != '1)   meas_q <= meas_q + ONE;
      if (accept)    prev_q <= 1'b1;
      else if (miss) prev_q <= 1'b0;
      if (accept && prev_q) begin
        hist_q <= {hist_q[DEPTH-2:0], meas_q};
        if (!full) fill_q <= fill_q + CW'(1);
      end
      if (apply && full) tps_q <= med;
    end
  end

  assign tps = tps_q;

  a_r10_loads_median: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && full) |=> (tps_q == $past(med)));

  a_r10_otherwise_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply && full) |=> $stable(tps_q));

  a_r9_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));

endmodule

// File: rtl/pps_time_keeper.sv
module pps_time_keeper
  import ppt_pkg::*;
#(
  parameter  int NOM_TICKS  = 50_000_000,
  parameter  int WIN_TICKS  = 50,
  parameter  int HIST_DEPTH = 5,
  localparam int TW         = $clog2(NOM_TICKS) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pps_in,
  input  logic          tod_load,
  input  logic [4:0]    tod_hr_in,
  input  logic [5:0]    tod_min_in,
  input  logic [5:0]    tod_sec_in,
  input  logic          cal_req,
  output logic [TW-1:0] sub_tick,
  output logic [4:0]    hr_out,
  output logic [5:0]    min_out,
  output logic [5:0]    sec_out,
  output logic [1:0]    lock_state,
  output logic [TW-1:0] sec_len
);
  logic [TW-1:0] tps, tick;
  lock_e         state;
  logic          accept, late, rollover, miss;
  logic          enter_hold, apply, advance;
  tod_t          tod_in, cur;

  ppt_tick_fsm #(.TW(TW), .WIN(WIN_TICKS)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .pps_in   (pps_in),
    .tps      (tps),
    .tick     (tick),
    .state    (state),
    .accept   (accept),
    .late     (late),
    .rollover (rollover),
    .miss     (miss)
  );

  assign enter_hold = miss && (state == ST_SYNC);
  assign apply      = cal_req || enter_hold;
  assign advance    = (accept && !late) || rollover;
  assign tod_in     = '{hr: tod_hr_in, mn: tod_min_in, sc: tod_sec_in};

  ppt_tod u_tod (
    .clk      (clk),
    .rst_n    (rst_n),
    .tod_load (tod_load),
    .tod_in   (tod_in),
    .accept   (accept),
    .advance  (advance),
    .cur      (cur)
  );

  ppt_calib #(.TW(TW), .NOM(NOM_TICKS), .DEPTH(HIST_DEPTH)) u_cal (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .miss   (miss),
    .apply  (apply),
    .tps    (tps)
  );

  assign sub_tick   = tick;
  assign hr_out     = cur.hr;
  assign min_out    = cur.mn;
  assign sec_out    = cur.sc;
  assign lock_state = state;
  assign sec_len    = tps;

  a_r5_late_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    (late && !rollover) |-> !advance);

  a_r7_hold_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
    enter_hold |=> (state == ST_HOLD));

endmodule

// File: tb/pps_time_keeper_test.sv
module pps_time_keeper_test;
  localparam int NOM = 100;
  localparam int WIN = 4;
  localparam int TW  = 9;

  logic clk = 1'b0, rst_n = 1'b0, pps = 1'b0, tod_ld = 1'b0, cal = 1'b0;
  logic [4:0] thr = '0;
  logic [5:0] tmn = '0, tsc = '0;
  wire  [TW-1:0] tick, slen;
  wire  [4:0] hr;
  wire  [5:0] mn, sc;
  wire  [1:0] st;
  int checks = 0, errors = 0;

  pps_time_keeper #(.NOM_TICKS(NOM), .WIN_TICKS(WIN), .HIST_DEPTH(5)) uut (
    .clk(clk), .rst_n(rst_n), .pps_in(pps), .tod_load(tod_ld),
    .tod_hr_in(thr), .tod_min_in(tmn), .tod_sec_in(tsc), .cal_req(cal),
    .sub_tick(tick), .hr_out(hr), .min_out(mn), .sec_out(sc),
    .lock_state(st), .sec_len(slen)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pps;
    pps = 1'b1; @(negedge clk); pps = 1'b0;
  endtask

  task automatic load_tod(int h, int m, int s);
    thr = 5'(h); tmn = 6'(m); tsc = 6'(s); tod_ld = 1'b1;
    @(negedge clk); tod_ld = 1'b0;
  endtask

  task automatic t_reset;
    waitn(3);
    chk("R1", "tick", int'(tick), 0);
    chk("R1", "hms", int'(hr) * 3600 + int'(mn) * 60 + int'(sc), 0);
    chk("R1", "state", int'(st), 0);
    chk("R1", "len", int'(slen), NOM);
    rst_n = 1'b1;
  endtask

  task automatic t_unsync_first;
    load_tod(12, 34, 56);
    chk("R6", "hour before edge", int'(hr), 0);
    waitn(30);
    chk("R2", "still unlocked", int'(st), 0);
    pulse_pps;
    chk("R3", "tick after edge", int'(tick), 0);
    chk("R2", "locked", int'(st), 1);
    chk("R6", "hour", int'(hr), 12);
    chk("R6", "min", int'(mn), 34);
    chk("R6", "sec", int'(sc), 56);
    cal = 1'b1; @(negedge clk); cal = 1'b0;
    chk("R10", "len unchanged not full", int'(slen), NOM);
  endtask

  task automatic t_window;
    waitn(97);
    pulse_pps;
    chk("R5", "early tick", int'(tick), 0);
    chk("R5", "early advances", int'(sc), 57);
    waitn(102);
    chk("R8", "local rollover", int'(sc), 58);
    pulse_pps;
    chk("R5", "late tick", int'(tick), 0);
    chk("R5", "late no double", int'(sc), 58);
    waitn(50);
    pulse_pps;
    chk("R4", "outside ignored tick", int'(tick), 51);
    chk("R4", "outside ignored sec", int'(sc), 58);
  endtask

  task automatic t_holdover;
    waitn(53);
    chk("R7", "locked until window end", int'(st), 1);
    waitn(1);
    chk("R7", "holdover", int'(st), 2);
    chk("R10", "len kept, history short", int'(slen), NOM);
    waitn(95);
    chk("R8", "carry sec", int'(sc), 0);
    chk("R8", "carry min", int'(mn), 35);
    chk("R8", "hour kept", int'(hr), 12);
    waitn(97);
    pulse_pps;
    chk("R7", "relock", int'(st), 1);
    chk("R5", "relock advance", int'(sc), 1);
  endtask

  task automatic t_calibrate;
    waitn(96);  pulse_pps;
    waitn(102); pulse_pps;
    waitn(98);  pulse_pps;
    waitn(97);  pulse_pps;
    waitn(100); pulse_pps;
    chk("R9", "tick after feed", int'(tick), 0);
    cal = 1'b1; @(negedge clk); cal = 1'b0;
    chk("R10", "median on request", int'(slen), 99);
    waitn(97);
    chk("R8", "tick before short wrap", int'(tick), 98);
    waitn(1);
    chk("R8", "wrap at new length", int'(tick), 0);
    waitn(3);
    pulse_pps;
    waitn(104);
    chk("R7", "lost again", int'(st), 2);
    chk("R10", "median on loss", int'(slen), 101);
  endtask

  task automatic t_day_wrap;
    load_tod(23, 59, 59);
    waitn(92);
    pulse_pps;
    chk("R6", "loaded sec", int'(sc), 59);
    chk("R7", "relocked", int'(st), 1);
    waitn(101);
    chk("R8", "day wrap tick", int'(tick), 0);
    chk("R8", "day wrap", int'(hr) * 3600 + int'(mn) * 60 + int'(sc), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_unsync_first;
    t_window;
    t_holdover;
    t_calibrate;
    t_day_wrap;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule